// File: doc/BRIEF.md
# Accumulator ALU with Flag Generation

This block is the combinational arithmetic and logic unit for an eight-bit accumulator machine. In a single pass it takes an operation code, the two operands and the current flag byte. It returns a result, a write-back enable and a fully updated flag byte. It covers eight byte operations:

- add and add-with-carry
- subtract and subtract-with-borrow
- AND, XOR and OR
- compare

A separate wide mode adds two sixteen-bit values, the way a register pair is added to a pointer pair.

The byte operations follow the usual accumulator flag rules. The parity/overflow flag reports signed overflow for arithmetic and even parity for logic. Compare updates the flags like a subtraction but blocks the write-back, and takes its two undocumented copy bits from the operand. The wide add touches only carry, half-carry, the subtract flag and the two copy bits, and passes sign, zero and parity/overflow through unchanged. Fetching operands and writing registers are left to the surrounding datapath.

Top module: `byte_alu`

## Requirements
- R1: Add (code 0) gives A+B. C is the carry out of bit 7 and H is the carry out of bit 3. P/V is set when A and B have the same sign and the result sign differs from it. N is cleared.
- R2: Add-with-carry (code 1) adds the incoming C (flags_in bit 0) into the sum, into the nibble carry and into the byte carry. The other flag rules are those of R1.
- R3: Subtract (code 2) gives A-B. C is set when A<B and H is set when A[3:0]<B[3:0]. P/V is set when the signs of A and B differ and the result sign differs from the sign of A. N is set.
- R4: Subtract-with-borrow (code 3) also subtracts the incoming C, and includes it in both borrow tests. The other flag rules are those of R3.
- R5: AND (code 4) sets H, clears C and N, and sets P/V when the result has an even number of one bits.
- R6: XOR (code 5) and OR (code 6) clear H, C and N, and set P/V on even parity of the result.
- R7: Compare (code 7) forms A-B and sets S, Z, H, C, P/V and N as in R3. X and Y are taken from operand bits 3 and 5. wr_en is 0, and result still carries the difference.
- R8: In every byte mode, S is result bit 7 and Z is set when the result byte is zero. X is result bit 3 and Y is result bit 5, except in compare. result[15:8] is zero, and wr_en is 1 for codes 0 to 6.
- R9: With wide_mode high, result is opnd_a+opnd_b modulo 2^16. C is the carry out of bit 15 and H is the carry out of bit 11. N is cleared. X is result bit 11 and Y is result bit 13. S, Z and P/V are copied from flags_in. wr_en is 1, and op_sel has no effect.
- R10: The flag byte is laid out from bit 7 down as S, Z, Y, H, X, P/V, N, C. The operation codes are 0 to 7 in the order of R1 to R7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_sel | input | 3 | Byte operation code (see R10) |
| wide_mode | input | 1 | Select the sixteen-bit add |
| opnd_a | input | 16 | Accumulator in bits 7:0, or the full first word in wide mode |
| opnd_b | input | 16 | Operand in bits 7:0, or the full second word in wide mode |
| flags_in | input | 8 | Current flag byte |
| result | output | 16 | Computed value |
| wr_en | output | 1 | Result should be written back |
| flags_out | output | 8 | Updated flag byte |

## Verification
The bench goes after the signed-overflow edges, 0x7F+1 and 0x80-1. A unit that reported parity there, or that tested overflow against the wrong operand sign, would leave P/V clear. It checks the carry-in nibble cases, 0x0F+0 with carry and 0x10-0x0F with carry. A unit that dropped the incoming carry from the half-carry or borrow would miss H, or miss Z on the zero difference. A compare with operand 0x28 against an equal accumulator gives a zero difference but sets X and Y, which exposes copy bits taken from the result. Wide adds across 0x0FFF and 0xFFFF, with arbitrary op_sel and preset sign, zero and parity flags, catch a half-carry taken at the wrong bit and any leak of the byte flags into the wide path.

// File: rtl/byte_alu_pkg.sv
`timescale 1ns/1ps
package byte_alu_pkg;
   typedef enum logic [2:0] {
      ALU_ADD = 3'd0,
      ALU_ADC = 3'd1,
      ALU_SUB = 3'd2,
      ALU_SBC = 3'd3,
      ALU_AND = 3'd4,
      ALU_XOR = 3'd5,
      ALU_OR  = 3'd6,
      ALU_CMP = 3'd7
   } alu_op_e;

   // flag byte bit positions; X and Y positions match the result bits they copy
   localparam int unsigned FB_C  = 0;
   localparam int unsigned FB_N  = 1;
   localparam int unsigned FB_PV = 2;
   localparam int unsigned FB_X  = 3;
   localparam int unsigned FB_H  = 4;
   localparam int unsigned FB_Y  = 5;
   localparam int unsigned FB_Z  = 6;
   localparam int unsigned FB_S  = 7;
   localparam int unsigned FLAG_W = 8;
endpackage

// File: rtl/byte_alu_addsub.sv
`timescale 1ns/1ps
// Shared adder/subtractor: subtraction adds the inverted operand with an
// inverted carry-in, and the carries come back out as true borrows.
module byte_alu_addsub #(
   parameter int unsigned DW  = 8,
   parameter int unsigned NIB = 4
) (
   input  logic [DW-1:0] a,
   input  logic [DW-1:0] b,
   input  logic          sub,
   input  logic          cin,
   output logic [DW-1:0] sum,
   output logic          carry,
   output logic          half,
   output logic          ovf
);
   localparam int unsigned TOPB = DW - 1;

   generate
      if (NIB == 0 || NIB >= DW) begin : g_bad_nib
         $error("byte_alu_addsub: NIB must lie strictly inside DW");
      end
   endgenerate

   logic [DW-1:0] b_eff;
   logic          ci_eff;
   logic [DW:0]   full_sum;
   logic [NIB:0]  low_sum;

   always_comb begin
      b_eff    = sub ? ~b : b;
      ci_eff   = sub ? ~cin : cin;
      full_sum = {1'b0, a} + {1'b0, b_eff} + {{DW{1'b0}}, ci_eff};
      low_sum  = {1'b0, a[NIB-1:0]} + {1'b0, b_eff[NIB-1:0]} + {{NIB{1'b0}}, ci_eff};
      sum      = full_sum[DW-1:0];
      carry    = full_sum[DW] ^ sub;
      half     = low_sum[NIB] ^ sub;
      ovf      = (a[TOPB] == b_eff[TOPB]) && (full_sum[TOPB] != a[TOPB]);
   end
endmodule

// File: rtl/byte_alu_logic.sv
`timescale 1ns/1ps
// Bitwise unit with even-parity output built as a generated XOR chain.
module byte_alu_logic #(
   parameter int unsigned DW = 8
) (
   input  logic [DW-1:0] a,
   input  logic [DW-1:0] b,
   input  logic [1:0]    sel,   // 0 AND, 1 XOR, 2 OR
   output logic [DW-1:0] res,
   output logic          even
);
   logic [DW:0] chain;

   always_comb begin
      unique case (sel)
         2'd0:    res = a & b;
         2'd1:    res = a ^ b;
         default: res = a | b;
      endcase
   end

   assign chain[0] = 1'b1;
   generate
      for (genvar gi = 0; gi < DW; gi++) begin : g_par
         assign chain[gi+1] = chain[gi] ^ res[gi];
      end
   endgenerate
   assign even = chain[DW];
endmodule

// File: rtl/byte_alu.sv
`timescale 1ns/1ps
module byte_alu #(
   parameter int unsigned DW  = 8,
   parameter int unsigned NIB = 4,
   parameter int unsigned XB  = 3,
   parameter int unsigned YB  = 5
) (
   input  logic [2:0]      op_sel,
   input  logic            wide_mode,
   input  logic [2*DW-1:0] opnd_a,
   input  logic [2*DW-1:0] opnd_b,
   input  logic [7:0]      flags_in,
   output logic [2*DW-1:0] result,
   output logic            wr_en,
   output logic [7:0]      flags_out
);
   import byte_alu_pkg::*;

   localparam int unsigned WW   = 2 * DW;
   localparam int unsigned WNIB = WW - NIB;
   localparam int unsigned WXB  = WW - DW + XB;
   localparam int unsigned WYB  = WW - DW + YB;

   generate
      if (DW != FLAG_W) begin : g_bad_dw
         $error("byte_alu: DW must equal the flag byte width");
      end
      if (YB >= DW || XB >= DW || NIB >= DW) begin : g_bad_pos
         $error("byte_alu: bit positions out of range");
      end
   endgenerate

   alu_op_e op;
   logic    is_sub, use_c, is_logic, is_cmp;

   always_comb begin
      op       = alu_op_e'(op_sel);
      is_cmp   = (op == ALU_CMP);
      is_sub   = (op == ALU_SUB) || (op == ALU_SBC) || is_cmp;
      use_c    = (op == ALU_ADC) || (op == ALU_SBC);
      is_logic = (op == ALU_AND) || (op == ALU_XOR) || (op == ALU_OR);
   end

   // byte arithmetic path
   logic [DW-1:0] ar_sum;
   logic          ar_c, ar_h, ar_v;
   byte_alu_addsub #(.DW(DW), .NIB(NIB)) u_byte_arith (
      .a     (opnd_a[DW-1:0]),
      .b     (opnd_b[DW-1:0]),
      .sub   (is_sub),
      .cin   (use_c & flags_in[FB_C]),
      .sum   (ar_sum),
      .carry (ar_c),
      .half  (ar_h),
      .ovf   (ar_v)
   );

   // bitwise path
   logic [DW-1:0] lg_res;
   logic          lg_even;
   byte_alu_logic #(.DW(DW)) u_bitwise (
      .a    (opnd_a[DW-1:0]),
      .b    (opnd_b[DW-1:0]),
      .sel  (op_sel[1:0]),
      .res  (lg_res),
      .even (lg_even)
   );

   // wide add path, half carry taken NIB bits below the top
   logic [WW-1:0] wd_sum;
   logic          wd_c, wd_h, wd_v;
   byte_alu_addsub #(.DW(WW), .NIB(WNIB)) u_wide_add (
      .a     (opnd_a),
      .b     (opnd_b),
      .sub   (1'b0),
      .cin   (1'b0),
      .sum   (wd_sum),
      .carry (wd_c),
      .half  (wd_h),
      .ovf   (wd_v)
   );

   logic [DW-1:0] byte_res;
   logic [DW-1:0] xy_src;

   always_comb begin
      byte_res  = is_logic ? lg_res : ar_sum;
      xy_src    = is_cmp ? opnd_b[DW-1:0] : byte_res;
      flags_out = '0;
      if (wide_mode) begin
         result            = wd_sum;
         wr_en             = 1'b1;
         flags_out[FB_S]   = flags_in[FB_S];
         flags_out[FB_Z]   = flags_in[FB_Z];
         flags_out[FB_PV]  = flags_in[FB_PV];
         flags_out[FB_C]   = wd_c;
         flags_out[FB_H]   = wd_h;
         flags_out[FB_N]   = 1'b0;
         flags_out[FB_X]   = wd_sum[WXB];
         flags_out[FB_Y]   = wd_sum[WYB];
      end else begin
         result            = {{DW{1'b0}}, byte_res};
         wr_en             = !is_cmp;
         flags_out[FB_S]   = byte_res[DW-1];
         flags_out[FB_Z]   = (byte_res == '0);
         flags_out[FB_X]   = xy_src[XB];
         flags_out[FB_Y]   = xy_src[YB];
         flags_out[FB_N]   = is_sub;
         if (is_logic) begin
            flags_out[FB_H]  = (op == ALU_AND);
            flags_out[FB_C]  = 1'b0;
            flags_out[FB_PV] = lg_even;
         end else begin
            flags_out[FB_H]  = ar_h;
            flags_out[FB_C]  = ar_c;
            flags_out[FB_PV] = ar_v;
         end
      end
   end

   // guards next to the flag merge
   always_comb begin
      if (!wide_mode && op_sel == 3'd7) begin
         a_r7_cmp_no_write: assert (!wr_en && flags_out[FB_N])
            else $error("compare must not write back and must set N");
      end
      if (!wide_mode && op_sel != 3'd7) begin
         a_r8_zero_flag: assert (flags_out[FB_Z] == (result == '0))
            else $error("zero flag disagrees with result");
      end
      if (!wide_mode && op_sel[2] && op_sel != 3'd7) begin
         a_r5_logic_clears_cn: assert (!flags_out[FB_C] && !flags_out[FB_N])
            else $error("bitwise op left C or N set");
      end
      if (wide_mode) begin
         a_r9_wide_keeps_szv: assert (flags_out[FB_S] == flags_in[FB_S] &&
                                      flags_out[FB_Z] == flags_in[FB_Z] &&
                                      flags_out[FB_PV] == flags_in[FB_PV] &&
                                      !flags_out[FB_N] && wr_en)
            else $error("wide add disturbed S/Z/PV or N");
      end
      if (!wide_mode) begin
         a_r8_upper_clear: assert (result[WW-1:DW] == '0)
            else $error("byte op drove upper result bits");
      end
   end
endmodule

// File: tb/byte_alu_tb.sv
`timescale 1ns/1ps
module byte_alu_tb;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2 clk = ~clk;   // 250 MHz

   logic [2:0]  op_sel    = '0;
   logic        wide_mode = 1'b0;
   logic [15:0] opnd_a    = '0;
   logic [15:0] opnd_b    = '0;
   logic [7:0]  flags_in  = '0;
   logic [15:0] result;
   logic        wr_en;
   logic [7:0]  flags_out;

   byte_alu u_dut (
      .op_sel    (op_sel),
      .wide_mode (wide_mode),
      .opnd_a    (opnd_a),
      .opnd_b    (opnd_b),
      .flags_in  (flags_in),
      .result    (result),
      .wr_en     (wr_en),
      .flags_out (flags_out)
   );

   typedef struct {
      logic [15:0] res;
      logic        we;
      logic [7:0]  fl;
      string       tag;
   } exp_t;

   exp_t exp_q[$];
   int   n_tests = 0;
   int   n_fail  = 0;
   bit   done    = 0;

   // independent reference: flag byte S Z Y H X PV N C from bit 7 down
   function automatic exp_t model(input logic [2:0] op, input logic w,
                                  input logic [15:0] a16, input logic [15:0] b16,
                                  input logic [7:0] f, input string tag);
      exp_t e;
      int r, ci, an, bn;
      logic [7:0] a, b, rb, xy;
      logic [15:0] rw;
      logic s, z, y, h, x, v, n, cy;
      e.tag = tag;
      if (w) begin
         r  = int'(a16) + int'(b16);
         rw = 16'(r);
         cy = (r > 65535);
         h  = (int'(a16 & 16'h0FFF) + int'(b16 & 16'h0FFF)) > 4095;
         e.res = rw;
         e.we  = 1'b1;
         e.fl  = {f[7], f[6], rw[13], h, rw[11], f[2], 1'b0, cy};
         return e;
      end
      a = a16[7:0]; b = b16[7:0];
      an = int'(a % 16); bn = int'(b % 16);
      v = 0; h = 0; cy = 0; n = 0;
      case (op)
         3'd0, 3'd1: begin
            ci = (op == 3'd1) ? int'(f[0]) : 0;
            r  = int'(a) + int'(b) + ci;
            rb = 8'(r);
            cy = (r > 255);
            h  = (an + bn + ci) > 15;
            v  = (a[7] == b[7]) && (rb[7] != a[7]);
         end
         3'd2, 3'd3, 3'd7: begin
            ci = (op == 3'd3) ? int'(f[0]) : 0;
            r  = int'(a) - int'(b) - ci;
            rb = 8'(r);
            cy = (r < 0);
            h  = (an - bn - ci) < 0;
            v  = (a[7] != b[7]) && (rb[7] != a[7]);
            n  = 1;
         end
         default: begin
            rb = (op == 3'd4) ? (a & b) : (op == 3'd5) ? (a ^ b) : (a | b);
            h  = (op == 3'd4);
            v  = ($countones(rb) % 2) == 0;
         end
      endcase
      s  = rb[7];
      z  = (rb == 8'h00);
      xy = (op == 3'd7) ? b : rb;
      x  = xy[3];
      y  = xy[5];
      e.res = {8'h00, rb};
      e.we  = (op != 3'd7);
      e.fl  = {s, z, y, h, x, v, n, cy};
      return e;
   endfunction

   task automatic drive(input logic [2:0] op, input logic w, input logic [15:0] a,
                        input logic [15:0] b, input logic [7:0] f, input string tag);
      @(posedge clk);
      op_sel = op; wide_mode = w; opnd_a = a; opnd_b = b; flags_in = f;
      exp_q.push_back(model(op, w, a, b, f, tag));
   endtask

   // monitor: compares half a cycle after each drive
   initial begin
      forever begin
         @(negedge clk);
         if (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            n_tests++;
            if (result !== e.res || wr_en !== e.we || flags_out !== e.fl) begin
               n_fail++;
               $display("FAIL %s: got res=%h we=%b fl=%b exp res=%h we=%b fl=%b",
                        e.tag, result, wr_en, flags_out, e.res, e.we, e.fl);
            end
         end
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: got timeout exp completion");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   string tags[8] = '{"R1", "R2", "R3", "R4", "R5", "R6", "R6", "R7"};

   initial begin
      repeat (4) @(posedge clk);
      rst_n = 1'b1;
      // reset-state inputs: add of zeros gives zero with Z set (R8)
      drive(3'd0, 0, 16'h0000, 16'h0000, 8'h00, "R8");
      // R1 signed overflow and nibble carry; carry out to zero
      drive(3'd0, 0, 16'h007F, 16'h0001, 8'h00, "R1");
      drive(3'd0, 0, 16'h00FF, 16'h0001, 8'h00, "R1");
      // R2 carry-in reaches nibble and byte carry
      drive(3'd1, 0, 16'h000F, 16'h0000, 8'h01, "R2");
      drive(3'd1, 0, 16'h00FF, 16'h0000, 8'h01, "R2");
      drive(3'd1, 0, 16'h000F, 16'h0000, 8'h00, "R2");
      // R3 borrow and overflow
      drive(3'd2, 0, 16'h0000, 16'h0001, 8'h00, "R3");
      drive(3'd2, 0, 16'h0080, 16'h0001, 8'h00, "R3");
      // R4 incoming carry in both borrow tests
      drive(3'd3, 0, 16'h0010, 16'h000F, 8'h01, "R4");
      drive(3'd3, 0, 16'h0000, 16'h0000, 8'h01, "R4");
      // R5/R6 parity and H handling
      drive(3'd4, 0, 16'h00F3, 16'h003C, 8'hFF, "R5");
      drive(3'd5, 0, 16'h00F0, 16'h0001, 8'hFF, "R6");
      drive(3'd6, 0, 16'h0000, 16'h0000, 8'hFF, "R6");
      // R7 equal compare: zero difference but X/Y from operand
      drive(3'd7, 0, 16'h0028, 16'h0028, 8'h00, "R7");
      drive(3'd7, 0, 16'h0010, 16'h0020, 8'h00, "R7");
      // R9 wide half carry at bit 11, carry out at bit 15, op_sel ignored
      drive(3'd7, 1, 16'h0FFF, 16'h0001, 8'hC4, "R9");
      drive(3'd2, 1, 16'hFFFF, 16'h0001, 8'h00, "R9");
      drive(3'd5, 1, 16'h1234, 16'h1111, 8'h44, "R9");
      // R10 code order: code 6 must be OR not AND
      drive(3'd6, 0, 16'h0081, 16'h0042, 8'h00, "R10");
      for (int i = 0; i < 800; i++) begin
         logic [2:0] op;
         logic w;
         op = 3'($urandom);
         w  = ($urandom % 8) == 0;
         drive(op, w, 16'($urandom), 16'($urandom), 8'($urandom), w ? "R9" : tags[op]);
      end
      while (exp_q.size() > 0) @(posedge clk);
      @(posedge clk);
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule